// File: doc/BRIEF.md
# Stereo Soft Mute Ramp with Zero-Run Flag

This block sits in a stereo sample path and scales both channels by a shared gain. While the mute request is high, the gain falls one step per frame toward silence. When the request drops, the gain climbs one step per frame back to unity. A frame is one cycle in which the frame strobe is high. Because the gain is a single step counter that can move either way, a mute that is cancelled partway turns round at the level it has reached and climbs back at the same rate. The result is a linear fade that never jumps.

Next to the fade, a run counter watches the incoming samples. It raises a flag once both channels have been exactly zero for a long unbroken run of frames. The flag drops on the first frame in which either channel is nonzero. Downstream logic can use the flag to power down or to mark silence.

Top module: `soft_mute_zd`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: both outputs become 0, `zero_flag` becomes 0, the zero-run count goes to 0 and the gain goes to unity (step 1024 of 1024).
- R2: On each frame with `mute_req` high, the gain step decreases by one until it reaches 0. Starting from unity, 1024 such frames reach full attenuation.
- R3: On each frame with `mute_req` low, the gain step increases by one until it reaches 1024. Starting from 0, 1024 such frames reach unity.
- R4: If `mute_req` drops before the step reaches 0, the step climbs back from its current value with no jump.
- R5: Between frames, the gain, the outputs and the flag hold their values, whatever the sample inputs do.
- R6: At the clock edge of a frame, each output is loaded with input × step / 1024, computed with the step held before that edge.
- R7: The quotient in R6 is rounded toward zero, so a negative sample never gives a result larger in magnitude than the exact quotient. Examples: −1 at step 1023 gives 0, and −1000 at step 512 gives −500.
- R8: At step 1024 each output equals its input exactly. At step 0 both outputs are 0.
- R9: `zero_flag` goes high at the edge of the 8192nd consecutive frame in which both channels are zero. It is still low after the 8191st.
- R10: The first frame in which either channel is nonzero clears `zero_flag` at that frame's edge and restarts the run, so another 8192 zero frames are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per stereo frame; qualifies the inputs |
| mute_req | input | 1 | High requests the fade to silence |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_out | output | 24 | Scaled left sample, registered |
| right_out | output | 24 | Scaled right sample, registered |
| zero_flag | output | 1 | High after a long run of all-zero frames |

## Verification
A wrong gain step shows on both outputs at the very next frame, because every frame scales the sample by the step held before that frame's edge. An off-by-one in the ramp ends therefore appears as a nonzero last sample or a missing unity sample. A zero-run counter that counts wrongly, fails to saturate or fails to restart shows only as a flag edge one or more frames off, and that edge may appear up to 8192 frames later. For this reason the bench follows complete runs up to and across the threshold, and checks the frame just before it.

// File: rtl/smz_pkg.sv
package smz_pkg;

    localparam int SMP_W_DEF    = 24;
    localparam int RAMP_LEN_DEF = 1024;
    localparam int RUN_LEN_DEF  = 8192;

    // direction the gain step moves on a frame
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_FALL = 2'd1,
        RAMP_RISE = 2'd2
    } ramp_dir_t;

    typedef struct packed {
        logic signed [SMP_W_DEF-1:0] left;
        logic signed [SMP_W_DEF-1:0] right;
    } stereo_t;

    // choose the ramp direction from the request and the step's position
    function automatic ramp_dir_t pick_dir(input logic muting,
                                           input logic at_floor,
                                           input logic at_top);
        if (muting)
            return at_floor ? RAMP_HOLD : RAMP_FALL;
        else
            return at_top ? RAMP_HOLD : RAMP_RISE;
    endfunction

endpackage

// File: rtl/smz_gain_step.sv
module smz_gain_step
    import smz_pkg::*;
#(
    parameter int RAMP_LEN = RAMP_LEN_DEF,
    localparam int STEP_W  = $clog2(RAMP_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute_req,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(RAMP_LEN);

    ramp_dir_t dir;

    always_comb begin
        dir = pick_dir(mute_req, step == '0, step == STEP_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= STEP_MAX;
        end else if (frame_stb) begin
            unique case (dir)
                RAMP_FALL: step <= step - STEP_W'(1);
                RAMP_RISE: step <= step + STEP_W'(1);
                default:   step <= step;
            endcase
        end
    end

    // R2: one step down per muted frame
    p_fall_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && mute_req && step != '0 |=> step == $past(step) - STEP_W'(1));

    // R3 and R4: one step up per released frame, from wherever it stood
    p_rise_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && !mute_req && step != STEP_MAX |=> step == $past(step) + STEP_W'(1));

    // R5: no movement between frames
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(step));

    // R2 and R3: the step stays within its range
    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step <= STEP_MAX);

endmodule

// File: rtl/smz_scaler.sv
module smz_scaler #(
    parameter int SMP_W    = 24,
    parameter int RAMP_LEN = 1024,
    parameter int CHANNELS = 2,
    localparam int STEP_W  = $clog2(RAMP_LEN) + 1,
    localparam int SHIFT   = $clog2(RAMP_LEN),
    localparam int PROD_W  = SMP_W + STEP_W + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_stb,
    input  logic [STEP_W-1:0]               step,
    input  logic [CHANNELS-1:0][SMP_W-1:0]  smp_in,
    output logic [CHANNELS-1:0][SMP_W-1:0]  smp_out
);

    localparam logic signed [PROD_W-1:0] BIAS = PROD_W'(RAMP_LEN - 1);

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
        logic signed [PROD_W-1:0] opd_a;
        logic signed [PROD_W-1:0] opd_b;
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] quot;

        always_comb begin
            opd_a = {{(PROD_W - SMP_W){smp_in[ch][SMP_W-1]}}, smp_in[ch]};
            opd_b = {{(PROD_W - STEP_W){1'b0}}, step};
            prod  = opd_a * opd_b;
            // bias negative products so the shift rounds toward zero
            quot  = (prod[PROD_W-1] ? prod + BIAS : prod) >>> SHIFT;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                smp_out[ch] <= '0;
            else if (frame_stb)
                smp_out[ch] <= quot[SMP_W-1:0];
        end

        // R6: the scaled value fits the sample width
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            frame_stb |-> (quot[PROD_W-1:SMP_W-1] == '0) || (&quot[PROD_W-1:SMP_W-1]));

        // R7: the result never points away from the input's sign
        p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
            frame_stb && !smp_in[ch][SMP_W-1] |=> !smp_out[ch][SMP_W-1]);

        // R5: outputs hold between frames
        p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_stb |=> $stable(smp_out[ch]));
    end

endmodule

// File: rtl/smz_zero_run.sv
module smz_zero_run #(
    parameter int SMP_W   = 24,
    parameter int RUN_LEN = 8192,
    localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [SMP_W-1:0] left_in,
    input  logic [SMP_W-1:0] right_in,
    output logic             zero_flag
);

    localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic             both_zero;

    always_comb begin
        both_zero = (left_in == '0) && (right_in == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (frame_stb) begin
            if (!both_zero)
                run_cnt <= '0;
            else if (run_cnt != RUN_TOP)
                run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    always_comb begin
        zero_flag = (run_cnt == RUN_TOP);
    end

    // R10: a nonzero frame clears the flag at its edge
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && !both_zero |=> !zero_flag);

    // R9: the flag rises only at a frame edge with zero input
    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_flag && !(frame_stb && both_zero) |=> !zero_flag);

    // R9: the counter saturates
    p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_TOP);

endmodule

// File: rtl/soft_mute_zd.sv
module soft_mute_zd
    import smz_pkg::*;
#(
    parameter int SMP_W    = SMP_W_DEF,
    parameter int RAMP_LEN = RAMP_LEN_DEF,
    parameter int RUN_LEN  = RUN_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             mute_req,
    input  logic [SMP_W-1:0] left_in,
    input  logic [SMP_W-1:0] right_in,
    output logic [SMP_W-1:0] left_out,
    output logic [SMP_W-1:0] right_out,
    output logic             zero_flag
);

    localparam int STEP_W = $clog2(RAMP_LEN) + 1;
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(RAMP_LEN);

    logic [STEP_W-1:0]       step;
    logic [1:0][SMP_W-1:0]   pair_in;
    logic [1:0][SMP_W-1:0]   pair_out;

    always_comb begin
        pair_in[0] = left_in;
        pair_in[1] = right_in;
        left_out   = pair_out[0];
        right_out  = pair_out[1];
    end

    smz_gain_step #(
        .RAMP_LEN (RAMP_LEN)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .step      (step)
    );

    smz_scaler #(
        .SMP_W    (SMP_W),
        .RAMP_LEN (RAMP_LEN),
        .CHANNELS (2)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .step      (step),
        .smp_in    (pair_in),
        .smp_out   (pair_out)
    );

    smz_zero_run #(
        .SMP_W   (SMP_W),
        .RUN_LEN (RUN_LEN)
    ) u_zero (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .left_in   (left_in),
        .right_in  (right_in),
        .zero_flag (zero_flag)
    );

    // R8: at unity the sample passes unchanged
    p_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && step == STEP_MAX |=> left_out == $past(left_in) && right_out == $past(right_in));

    // R8: at full attenuation the output is silent
    p_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && step == '0 |=> left_out == '0 && right_out == '0);

endmodule

// File: tb/test_soft_mute_zd.sv
module test_soft_mute_zd;

    localparam int W    = 24;
    localparam int RL   = 1024;
    localparam int RUNL = 8192;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_stb;
    logic          mute_req;
    logic [W-1:0]  left_in;
    logic [W-1:0]  right_in;
    logic [W-1:0]  left_out;
    logic [W-1:0]  right_out;
    logic          zero_flag;

    int checks = 0;
    int fails  = 0;
    int m_step = RL;   // bench model of the gain step
    int m_run  = 0;    // bench model of the zero run

    always #2.5 clk = ~clk;

    soft_mute_zd i_soft_mute_zd (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .left_in   (left_in),
        .right_in  (right_in),
        .left_out  (left_out),
        .right_out (right_out),
        .zero_flag (zero_flag)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pattern(input int i, input int ch);
        int h;
        case (i % 8)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            2: return ch ? 24'hFFFFFF : 24'h000001;
            3: return ch ? 24'h000001 : 24'hFFFFFF;
            4: return W'(-1000);
            5: return W'(513 + ch);
            default: begin
                h = i * 1103515245 + ch * 12345 + 777;
                return h[W-1:0];
            end
        endcase
    endfunction

    function automatic longint scaled(input logic [W-1:0] s, input int st);
        longint sv;
        sv = longint'($signed(s));
        return (sv * st) / RL;   // integer division truncates toward zero
    endfunction

    // one frame, then one idle cycle with junk inputs
    task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r,
                         input logic m, input string req);
        logic [W-1:0] lo, ro;
        logic         fl;
        frame_stb = 1'b1;
        left_in   = l;
        right_in  = r;
        mute_req  = m;
        @(posedge clk);
        #1;
        chk(req, "left_out", longint'($signed(left_out)), scaled(l, m_step));
        chk(req, "right_out", longint'($signed(right_out)), scaled(r, m_step));
        if (m && m_step > 0)       m_step--;
        else if (!m && m_step < RL) m_step++;
        if (l == '0 && r == '0) begin
            if (m_run < RUNL) m_run++;
        end else begin
            m_run = 0;
        end
        chk(req, "zero_flag", longint'(zero_flag), longint'(m_run == RUNL));
        lo = left_out; ro = right_out; fl = zero_flag;
        frame_stb = 1'b0;
        left_in   = 24'h5A5A5A;
        right_in  = 24'h000000;
        mute_req  = ~m;
        @(posedge clk);
        #1;
        // R5: nothing moves between frames
        chk("R5", "hold", longint'({left_out, right_out, zero_flag}),
            longint'({lo, ro, fl}));
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        frame_stb = 1'b1;
        mute_req  = 1'b0;
        left_in   = 24'h123456;
        right_in  = 24'h000000;
        repeat (4) @(posedge clk);
        #1;
        // R1: reset clears the outputs and the flag
        chk("R1", "left_out", longint'(left_out), 0);
        chk("R1", "right_out", longint'(right_out), 0);
        chk("R1", "zero_flag", longint'(zero_flag), 0);
        frame_stb = 1'b0;
        rst_n     = 1'b1;
        @(posedge clk);
        #1;

        // R1 and R8: unity gain after reset
        for (int i = 0; i < 24; i++)
            frame(pattern(i, 0), pattern(i, 1), 1'b0, "R8");

        // R2, R6, R7: full fall, with sign and rounding corners
        for (int i = 0; i < 1030; i++)
            frame(pattern(i + 3, 0), pattern(i + 5, 1), 1'b1, "R2");
        // R8: full attenuation is silent
        frame(24'h7FFFFF, 24'h800000, 1'b1, "R8");

        // R3: full rise
        for (int i = 0; i < 1030; i++)
            frame(pattern(i + 1, 0), pattern(i + 2, 1), 1'b0, "R3");

        // R4: cancel partway and climb back from the reached level
        for (int i = 0; i < 300; i++)
            frame(pattern(i, 0), pattern(i + 4, 1), 1'b1, "R4");
        for (int i = 0; i < 310; i++)
            frame(pattern(i + 6, 0), pattern(i, 1), 1'b0, "R4");

        // R7: rounding at chosen steps: drop to step 512
        for (int i = 0; i < 512; i++)
            frame(W'(-1000), 24'hFFFFFF, 1'b1, "R7");
        frame(W'(-1000), W'(-3), 1'b0, "R7");

        // R9: the flag needs 8192 unbroken zero frames
        for (int i = 0; i < RUNL; i++)
            frame('0, '0, 1'b0, "R9");
        frame('0, '0, 1'b0, "R9");
        // R10: one nonzero channel clears at once
        frame('0, 24'h000005, 1'b0, "R10");
        for (int i = 0; i < RUNL; i++)
            frame('0, '0, 1'b0, "R10");
        frame(W'(-3), '0, 1'b0, "R10");
        frame('0, '0, 1'b0, "R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule